// File: doc/BRIEF.md
# Write-Only I2C Receiver for a Display Controller

This block is the serial front end of a segment display controller. It listens on a two-wire I2C bus and accepts write transfers only. A transfer begins with an address byte. The upper six bits of that address are fixed, and bit 1 must equal the level on a strapping pin, so two controllers can share one bus. After the address, the master sends control bytes. Each control byte picks whether the bytes that follow are display memory data or commands. It also says whether a single byte follows before the next control byte, or whether all bytes up to the end of the transfer are of that type.

Display data leaves the block on a one-cycle write port. The write address comes from an internal pointer that advances by one after every stored byte and wraps at the top of the memory. Command bytes leave on a one-cycle strobe, which the downstream command decoder consumes. That decoder can reload the memory pointer through a load input. The block pulls SDA low to acknowledge only while it is addressed. It follows STOP and repeated START conditions. It never stretches the clock and never answers a read.

Top module: `dispI2cWriteRx`

## Requirements
- R1: An address byte with bits 7..2 equal to 011100, bit 1 equal to `addrPin` and bit 0 (R/W) equal to 0 is acknowledged, and `busy` rises.
- R2: An address byte whose bit 1 differs from `addrPin` is not acknowledged. No later byte of that transfer is acknowledged, and none produces a memory write or a command.
- R3: An address byte that matches but has R/W = 1 is not acknowledged. The block stays idle (`busy` low) and emits nothing.
- R4: In the first byte after an acknowledged address (the control byte), bit 6 selects the type of the following bytes: 1 = display data and 0 = command. A display data byte gives exactly one `ramWe` pulse carrying that byte in `ramWdata`.
- R5: A command byte gives exactly one single-cycle `cmdValid` pulse with the byte on `cmdData`. `ramWe` and `cmdValid` are never high in the same cycle.
- R6: When bit 7 of a control byte is 1, exactly one data or command byte follows, and the next byte is read as a new control byte.
- R7: When bit 7 of a control byte is 0, every later byte up to STOP or repeated START is of the type selected by that control byte.
- R8: Each display data write uses the current pointer as `ramAddr`. The pointer then advances by one and wraps from the top address to 0. It resets to 0.
- R9: A cycle with `setRamPtr` high loads `ramPtrLoad` into the pointer. The next display write goes to the loaded address.
- R10: A STOP condition ends the transfer and drops `busy`. Outside an addressed transfer, `ramWe` and `cmdValid` stay low.
- R11: A repeated START ends the current transfer and starts a new address phase, with no STOP needed in between.
- R12: The acknowledge drives `sdaOe` high from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit. `sdaOe` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock line level |
| sdaIn | input | 1 | I2C data line level |
| addrPin | input | 1 | Strap that sets address bit 1 |
| setRamPtr | input | 1 | Load strobe for the display memory pointer |
| ramPtrLoad | input | RAM_AW | Value loaded into the pointer |
| sdaOe | output | 1 | Pull SDA low (acknowledge) when high |
| ramWe | output | 1 | Display memory write strobe, one cycle |
| ramAddr | output | RAM_AW | Display memory write address |
| ramWdata | output | 8 | Display memory write data |
| cmdValid | output | 1 | Command byte strobe, one cycle |
| cmdData | output | 8 | Command byte |
| busy | output | 1 | An addressed write transfer is in progress |

## Verification
The assertions check, on every cycle, the rules that hold regardless of bus traffic:
- the acknowledge is driven only inside an addressed transfer;
- write and command strobes last one cycle, never coincide, and never appear while idle;
- each memory write address follows the previous write, or a pointer load, by exactly one.

Only the bench's scenarios can show the protocol behaviour that depends on the bus history:
- address decoding against the strap pin;
- refusal of reads;
- how the continuation flag and the type flag route bytes;
- pointer wrap;
- how STOP and repeated START end a transfer.

// File: rtl/dispRxPkg.sv
package dispRxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_SKIP
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ackSet;
    logic ramWr;
    logic cmdWr;
  } ctrlStrobe_t;

  // bus events from datapath to control
  typedef struct packed {
    logic       startEvt;
    logic       stopEvt;
    logic       byteEvt;
    logic [7:0] rxByte;
  } busEvent_t;

endpackage

// File: rtl/dispRxDatapath.sv
module dispRxDatapath
  import dispRxPkg::*;
#(
  parameter int RAM_AW      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              setRamPtr,
  input  logic [RAM_AW-1:0] ramPtrLoad,
  input  ctrlStrobe_t       strobe,
  output busEvent_t         evt,
  output logic              sdaOe,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic              cmdValid,
  output logic [7:0]        cmdData
);

  localparam int CNT_W    = 4;
  localparam int LAST_BIT = 7;
  localparam int ACK_BIT  = 8;

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] shiftReg;
  logic ackArm;
  logic [RAM_AW-1:0] ramPtr, ptrNow;

  // line synchronisers, reset to the idle-high bus level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclD     <= sclS;
      sdaD     <= sdaS;
    end
  end

  assign sclS    = sclChain[SYNC_STAGES-1];
  assign sdaS    = sdaChain[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;

  assign evt.startEvt = sclS & sclD & sdaD & ~sdaS;
  assign evt.stopEvt  = sclS & sclD & ~sdaD & sdaS;
  assign evt.byteEvt  = sclRise && (bitCnt == CNT_W'(LAST_BIT));
  assign evt.rxByte   = {shiftReg[6:0], sdaS};

  // bit counter and shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (evt.startEvt || evt.stopEvt) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt == CNT_W'(ACK_BIT)) begin
        bitCnt <= '0;
      end else begin
        bitCnt   <= bitCnt + CNT_W'(1);
        shiftReg <= {shiftReg[6:0], sdaS};
      end
    end
  end

  // acknowledge driver: low phase of the ninth clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackArm <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (evt.startEvt || evt.stopEvt) begin
      ackArm <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      if (strobe.ackSet) ackArm <= 1'b1;
      if (sclFall) begin
        if (bitCnt == CNT_W'(ACK_BIT) && ackArm) begin
          sdaOe  <= 1'b1;
          ackArm <= 1'b0;
        end else begin
          sdaOe <= 1'b0;
        end
      end
    end
  end

  // display memory pointer and output registers
  assign ptrNow = setRamPtr ? ramPtrLoad : ramPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramPtr   <= '0;
      ramWe    <= 1'b0;
      ramAddr  <= '0;
      ramWdata <= '0;
      cmdValid <= 1'b0;
      cmdData  <= '0;
    end else begin
      ramWe    <= strobe.ramWr;
      cmdValid <= strobe.cmdWr;
      if (strobe.ramWr) begin
        ramAddr  <= ptrNow;
        ramWdata <= evt.rxByte;
        ramPtr   <= ptrNow + RAM_AW'(1);
      end else begin
        ramPtr <= ptrNow;
      end
      if (strobe.cmdWr) cmdData <= evt.rxByte;
    end
  end

endmodule

// File: rtl/dispRxControl.sv
module dispRxControl
  import dispRxPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b011100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrPin,
  input  busEvent_t   evt,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  rxState_e state, stateNext;
  logic contFlag, ramSel;
  logic contNext, ramSelNext;
  logic addrHit;

  assign addrHit = (evt.rxByte[7:2] == DEV_ADDR_HI) && (evt.rxByte[1] == addrPin)
                   && !evt.rxByte[0];

  always_comb begin
    stateNext  = state;
    contNext   = contFlag;
    ramSelNext = ramSel;
    strobe     = '0;
    if (evt.startEvt) begin
      stateNext = ST_ADDR;
    end else if (evt.stopEvt) begin
      stateNext = ST_IDLE;
    end else if (evt.byteEvt) begin
      unique case (state)
        ST_ADDR: begin
          if (addrHit) begin
            strobe.ackSet = 1'b1;
            stateNext     = ST_CTRL;
          end else if (evt.rxByte[7:2] == DEV_ADDR_HI && evt.rxByte[1] == addrPin) begin
            stateNext = ST_IDLE;   // read request
          end else begin
            stateNext = ST_SKIP;
          end
        end
        ST_CTRL: begin
          strobe.ackSet = 1'b1;
          contNext      = evt.rxByte[7];
          ramSelNext    = evt.rxByte[6];
          stateNext     = ST_DATA;
        end
        ST_DATA: begin
          strobe.ackSet = 1'b1;
          strobe.ramWr  = ramSel;
          strobe.cmdWr  = !ramSel;
          if (contFlag) stateNext = ST_CTRL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      contFlag <= 1'b0;
      ramSel   <= 1'b0;
    end else begin
      state    <= stateNext;
      contFlag <= contNext;
      ramSel   <= ramSelNext;
    end
  end

  assign busy = (state == ST_CTRL) || (state == ST_DATA);

endmodule

// File: rtl/dispI2cWriteRx.sv
module dispI2cWriteRx
  import dispRxPkg::*;
#(
  parameter int         RAM_AW      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_ADDR_HI = 6'b011100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrPin,
  input  logic              setRamPtr,
  input  logic [RAM_AW-1:0] ramPtrLoad,
  output logic              sdaOe,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  output logic              cmdValid,
  output logic [7:0]        cmdData,
  output logic              busy
);

  ctrlStrobe_t strobe;
  busEvent_t   evt;

  dispRxDatapath #(.RAM_AW(RAM_AW), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .setRamPtr(setRamPtr), .ramPtrLoad(ramPtrLoad), .strobe(strobe), .evt(evt),
    .sdaOe(sdaOe), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .cmdValid(cmdValid), .cmdData(cmdData)
  );

  dispRxControl #(.DEV_ADDR_HI(DEV_ADDR_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .addrPin(addrPin), .evt(evt),
    .strobe(strobe), .busy(busy)
  );

endmodule

// File: rtl/dispRxChecker.sv
module dispRxChecker #(
  parameter int RAM_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaOe,
  input logic              busy,
  input logic              ramWe,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              cmdValid,
  input logic              setRamPtr,
  input logic [RAM_AW-1:0] ramPtrLoad
);

  logic [RAM_AW-1:0] expAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) expAddr <= '0;
    else if (setRamPtr) expAddr <= ramPtrLoad;
    else if (ramWe) expAddr <= ramAddr + RAM_AW'(1);
  end

  assert_ack_in_transfer_R12: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> busy);

  assert_cmd_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe);

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(ramWe && cmdValid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ramWe && !cmdValid));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramAddr == expAddr));

endmodule

bind dispI2cWriteRx dispRxChecker #(.RAM_AW(RAM_AW)) uChk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .busy(busy), .ramWe(ramWe),
  .ramAddr(ramAddr), .cmdValid(cmdValid), .setRamPtr(setRamPtr),
  .ramPtrLoad(ramPtrLoad)
);

// File: tb/tb_dispI2cWriteRx.sv
module tb_dispI2cWriteRx;

  localparam int AW = 6;
  localparam int Q  = 25;

  logic clk = 0;
  logic rstN = 0;
  logic mScl = 1, mSda = 1;
  logic addrPin = 0;
  logic setRamPtr = 0;
  logic [AW-1:0] ramPtrLoad = '0;
  logic sdaOe, ramWe, cmdValid, busy;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramWdata, cmdData;
  logic sdaLine;

  int checks = 0, fails = 0;
  int nRam = 0, nCmd = 0;
  logic [AW-1:0] logAddr [16];
  logic [7:0] logRam [16];
  logic [7:0] logCmd [16];

  assign sdaLine = mSda & ~sdaOe;

  always #4 clk = ~clk;

  dispI2cWriteRx dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .addrPin(addrPin),
    .setRamPtr(setRamPtr), .ramPtrLoad(ramPtrLoad), .sdaOe(sdaOe), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .cmdValid(cmdValid), .cmdData(cmdData),
    .busy(busy)
  );

  always @(negedge clk) begin
    if (ramWe && nRam < 16) begin
      logAddr[nRam] = ramAddr;
      logRam[nRam]  = ramWdata;
      nRam++;
    end
    if (cmdValid && nCmd < 16) begin
      logCmd[nCmd] = cmdData;
      nCmd++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1; w(Q); mScl = 1; w(Q);
    mSda = 0; w(Q); mScl = 0; w(Q);
  endtask

  task automatic busStop();
    mSda = 0; w(Q); mScl = 1; w(Q);
    mSda = 1; w(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; w(Q); mScl = 1; w(2*Q); mScl = 0; w(Q);
    end
    mSda = 1; w(Q); mScl = 1; w(Q);
    acked = ~sdaLine;
    w(Q); mScl = 0; w(Q);
  endtask

  task automatic clearLogs();
    nRam = 0; nCmd = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset busy", busy, 0);
    chk("R12 reset sdaOe", sdaOe, 0);
    chk("R4 reset ramWe", ramWe, 0);
    chk("R5 reset cmdValid", cmdValid, 0);
  endtask

  task automatic t_ramBurst();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h70, a); chk("R1 address ack", a, 1);
    chk("R1 busy after address", busy, 1);
    sendByte(8'h40, a); chk("R4 control ack", a, 1);
    sendByte(8'hAA, a); sendByte(8'h55, a); chk("R7 data ack", a, 1);
    w(10); chk("R12 ack released", sdaOe, 0);
    busStop();
    chk("R10 busy after stop", busy, 0);
    chk("R4 ram writes", nRam, 2);
    chk("R4 data0", logRam[0], 8'hAA); chk("R8 addr0", logAddr[0], 0);
    chk("R4 data1", logRam[1], 8'h55); chk("R8 addr1", logAddr[1], 1);
    chk("R4 no cmd", nCmd, 0);
  endtask

  task automatic t_cmdPair();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h70, a); sendByte(8'h00, a);
    sendByte(8'h12, a); sendByte(8'h34, a); chk("R5 cmd ack", a, 1);
    busStop();
    chk("R5 cmd count", nCmd, 2);
    chk("R5 cmd0", logCmd[0], 8'h12); chk("R7 cmd1", logCmd[1], 8'h34);
    chk("R5 no ram", nRam, 0);
  endtask

  task automatic t_mixed();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h70, a); sendByte(8'h80, a); sendByte(8'h21, a);
    sendByte(8'h40, a); chk("R6 second control ack", a, 1);
    sendByte(8'h66, a); sendByte(8'h77, a);
    busStop();
    chk("R6 one cmd", nCmd, 1); chk("R6 cmd", logCmd[0], 8'h21);
    chk("R6 ram count", nRam, 2);
    chk("R6 ram0", logRam[0], 8'h66); chk("R8 ram0 addr", logAddr[0], 2);
    chk("R6 ram1", logRam[1], 8'h77); chk("R8 ram1 addr", logAddr[1], 3);
  endtask

  task automatic t_wrongAddr();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h72, a); chk("R2 foreign address nack", a, 0);
    chk("R2 not busy", busy, 0);
    sendByte(8'h40, a); chk("R2 later byte nack", a, 0);
    sendByte(8'h99, a); chk("R2 data nack", a, 0);
    busStop();
    chk("R2 no ram", nRam, 0); chk("R2 no cmd", nCmd, 0);
  endtask

  task automatic t_read();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h71, a); chk("R3 read nack", a, 0);
    chk("R3 idle", busy, 0);
    sendByte(8'h40, a); chk("R3 following nack", a, 0);
    busStop();
    chk("R3 no ram", nRam, 0);
  endtask

  task automatic t_ptrLoad();
    logic a;
    clearLogs();
    ramPtrLoad = 6'h3E; setRamPtr = 1; w(1); setRamPtr = 0; ramPtrLoad = '0;
    busStart();
    sendByte(8'h70, a); sendByte(8'h40, a);
    sendByte(8'h01, a); sendByte(8'h02, a); sendByte(8'h03, a);
    busStop();
    chk("R9 count", nRam, 3);
    chk("R9 loaded addr", logAddr[0], 6'h3E);
    chk("R8 top addr", logAddr[1], 6'h3F);
    chk("R8 wrap addr", logAddr[2], 0);
    chk("R8 wrap data", logRam[2], 8'h03);
  endtask

  task automatic t_restart();
    logic a;
    clearLogs();
    busStart();
    sendByte(8'h70, a); sendByte(8'h40, a); sendByte(8'hC3, a);
    busStart();
    chk("R11 busy cleared by restart", busy, 0);
    sendByte(8'h70, a); chk("R11 address after restart", a, 1);
    sendByte(8'h00, a); sendByte(8'h5A, a);
    busStop();
    chk("R11 ram", nRam, 1); chk("R11 ram data", logRam[0], 8'hC3);
    chk("R8 ram addr", logAddr[0], 1);
    chk("R11 cmd", nCmd, 1); chk("R11 cmd data", logCmd[0], 8'h5A);
  endtask

  task automatic t_pinHigh();
    logic a;
    clearLogs();
    addrPin = 1;
    busStart();
    sendByte(8'h70, a); chk("R2 low-bit address ignored", a, 0);
    busStart();
    sendByte(8'h72, a); chk("R1 strap high address ack", a, 1);
    sendByte(8'h40, a); sendByte(8'hE7, a);
    busStop();
    chk("R1 ram count", nRam, 1); chk("R1 ram data", logRam[0], 8'hE7);
    addrPin = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    w(5);
    t_reset();
    rstN = 1;
    w(5);
    t_ramBurst();
    t_cmdPair();
    t_mixed();
    t_wrongAddr();
    t_read();
    t_ptrLoad();
    t_restart();
    t_pinHigh();
    w(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule